// File: doc/BRIEF.md
# Byte-Bus Serial Port Bridge

This block gives a processor a small serial port on its byte-wide bus. Two registers sit behind one address bit: a data register and a status register. Writing the data register sends the byte as an 8N1 serial character. Writing the status register sends the byte as two ASCII hexadecimal characters, high nibble first, which turns the port into a cheap debug printer. Reading the data register takes the oldest byte from a ring buffer of received characters. Reading the status register shows whether the transmitter can take a byte and whether a received byte is waiting.

The transmitter is a four-state machine: TX_IDLE, TX_START, TX_DATA, TX_STOP. TX_IDLE goes to TX_START when a character is ready and the far end is not holding us off. TX_START goes to TX_DATA after one bit time. TX_DATA goes to TX_STOP after the eighth data bit. TX_STOP goes back to TX_IDLE after one bit time. A second hexadecimal character waits in a pending slot and goes out before the holding register is looked at again.

The receiver has the same four states: RX_IDLE, RX_START, RX_DATA, RX_STOP. A low line moves RX_IDLE to RX_START. RX_START checks the line half a bit later: a low line goes to RX_DATA and a high line goes back to RX_IDLE. RX_DATA takes eight samples at the middle of each bit and then goes to RX_STOP. RX_STOP samples the stop bit and returns to RX_IDLE, storing the byte only if the stop bit is high. Flow control runs both ways. RTS is deasserted when the buffer is almost full. CTS is checked during reset and honoured only if it was low then.

Top module: `uart_bus_bridge`

## Requirements
- R1: After reset, txd and rts_o are 1, a status read returns 0x01 (with cts_i low during reset), and a data read returns 0x00.
- R2: A bus write with bus_reg=0 sends wdata as one 8N1 character: start bit 0, data bits LSB first, stop bit 1. Each bit lasts 16 ticks, and one tick is CLK_HZ/(BAUD*16) clocks.
- R3: A bus write with bus_reg=1 sends two characters: the high nibble's digit, then the low nibble's digit. Values 0-9 map to 0x30-0x39 and values 10-15 map to 0x41-0x46.
- R4: A status read (bus_reg=1) returns bits 7:2 = 0. Bit 0 is 1 when the holding register is empty and CTS is not blocking. Bit 1 is 1 when the receive buffer is not empty.
- R5: A write to either address while the holding register is empty is queued and sent after the character in flight, in write order. A write while the holding register is full is ignored.
- R6: cts_i is sampled during reset. If it was low, then while cts_i is high no new character starts and status bit 0 reads 0. If it was high, cts_i is ignored until the next reset.
- R7: Received 8N1 characters are sampled at mid-bit. A character whose stop bit is low is discarded.
- R8: Received bytes are read back in arrival order. Each data read removes one byte. Status bit 1 clears when the last byte is read. Status reads remove nothing.
- R9: When the buffer holds DEPTH bytes, further received bytes are dropped and the stored bytes stay intact.
- R10: rts_o is 1 when more than RTS_MARGIN entries are free and 0 otherwise. It is updated one clock after the fill level changes.
- R11: A data read while the buffer is empty returns 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | One-cycle bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_reg | input | 1 | Register select: 0 = data, 1 = status/hex |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_i | input | 1 | Far end not ready when high |
| rts_o | output | 1 | 1 = far end may send |

## Verification
Properties check the following on every cycle:
- The transmitter stays in TX_IDLE while CTS blocks it.
- A queued byte never leaves the holding register except by being loaded.
- The fill level goes up by exactly one on an accepted byte and stays put on a byte offered to a full buffer.
- rts_o follows the free-entry threshold one clock later.

The bench scenarios are needed for the serial waveforms themselves, the hex digit mapping for every nibble value, the dropping of bad frames and of bytes arriving at a full buffer, byte order after wraparound, and the reset-time choice between honouring and ignoring CTS.

// File: rtl/ubr_pkg.sv
`timescale 1ns/1ps
package ubr_pkg;
    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;

    // ASCII digit for one nibble: 0-9 then upper-case A-F
    function automatic logic [7:0] hex_ascii(input logic [3:0] n);
        if (n < 4'd10) return 8'h30 + {4'h0, n};
        else           return 8'h37 + {4'h0, n};
    endfunction
endpackage

// File: rtl/ubr_tick.sv
`timescale 1ns/1ps
module ubr_tick #(
    parameter int DIV = 81
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/ubr_tx.sv
`timescale 1ns/1ps
module ubr_tx
    import ubr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic       wr_hex,
    input  logic [7:0] wr_data,
    input  logic       cts_block,
    output logic       hold_busy,
    output logic       txd
);
    tx_state_e   state, state_nx;
    logic        hold_valid, hold_hex;
    logic [7:0]  hold_data;
    logic        pend_valid;
    logic [7:0]  pend_char;
    logic [7:0]  shreg;
    logic [2:0]  bit_idx;
    logic [3:0]  tcnt;
    logic        load_pend, load_hold, bit_end;

    always_comb begin
        load_pend = (state == TX_IDLE) && pend_valid && !cts_block;
        load_hold = (state == TX_IDLE) && !pend_valid && hold_valid && !cts_block;
        bit_end   = tick && (tcnt == 4'hF);
        state_nx  = state;
        unique case (state)
            TX_IDLE:  if (load_pend || load_hold)        state_nx = TX_START;
            TX_START: if (bit_end)                       state_nx = TX_DATA;
            TX_DATA:  if (bit_end && bit_idx == 3'd7)    state_nx = TX_STOP;
            TX_STOP:  if (bit_end)                       state_nx = TX_IDLE;
            default:                                     state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt       <= '0;
            bit_idx    <= '0;
            shreg      <= '0;
            pend_valid <= 1'b0;
            pend_char  <= '0;
            hold_valid <= 1'b0;
            hold_hex   <= 1'b0;
            hold_data  <= '0;
        end else begin
            if (state == TX_IDLE) tcnt <= '0;
            else if (tick)        tcnt <= tcnt + 4'd1;

            if (state == TX_IDLE)                bit_idx <= '0;
            else if (state == TX_DATA && bit_end) bit_idx <= bit_idx + 3'd1;

            if (load_pend) begin
                shreg      <= pend_char;
                pend_valid <= 1'b0;
            end else if (load_hold) begin
                shreg      <= hold_hex ? hex_ascii(hold_data[7:4]) : hold_data;
                pend_valid <= hold_hex;
                pend_char  <= hex_ascii(hold_data[3:0]);
            end else if (state == TX_DATA && bit_end) begin
                shreg <= {1'b0, shreg[7:1]};
            end

            if (wr_en && (!hold_valid || load_hold)) begin
                hold_valid <= 1'b1;
                hold_hex   <= wr_hex;
                hold_data  <= wr_data;
            end else if (load_hold) begin
                hold_valid <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_IDLE:  txd = 1'b1;
            TX_START: txd = 1'b0;
            TX_DATA:  txd = shreg[0];
            TX_STOP:  txd = 1'b1;
            default:  txd = 1'b1;
        endcase
    end

    assign hold_busy = hold_valid;

    // R6
    cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TX_IDLE && cts_block) |=> (state == TX_IDLE));

    // R5
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !load_hold) |=> hold_valid);
endmodule

// File: rtl/ubr_rx.sv
`timescale 1ns/1ps
module ubr_rx
    import ubr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd_s,
    output logic       push,
    output logic [7:0] push_data
);
    rx_state_e  state, state_nx;
    logic [3:0] tcnt;
    logic [2:0] bit_idx;
    logic [7:0] shreg;
    logic       half_pt, full_pt;

    always_comb begin
        half_pt  = tick && (tcnt == 4'd7);
        full_pt  = tick && (tcnt == 4'hF);
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (!rxd_s)                     state_nx = RX_START;
            RX_START: if (half_pt)                    state_nx = rxd_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (full_pt && bit_idx == 3'd7) state_nx = RX_STOP;
            RX_STOP:  if (full_pt)                    state_nx = RX_IDLE;
            default:                                  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt    <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            if (state == RX_IDLE || (state == RX_START && half_pt)) tcnt <= '0;
            else if (tick)                                         tcnt <= tcnt + 4'd1;

            if (state == RX_IDLE) bit_idx <= '0;
            else if (state == RX_DATA && full_pt) begin
                bit_idx <= bit_idx + 3'd1;
                shreg   <= {rxd_s, shreg[7:1]};
            end
        end
    end

    always_comb begin
        push      = (state == RX_STOP) && full_pt && rxd_s;
        push_data = shreg;
    end
endmodule

// File: rtl/ubr_ring.sv
`timescale 1ns/1ps
module ubr_ring #(
    parameter int DEPTH = 256,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [7:0]    push_data,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !full) |=> (count == $past(count) + CW'(1)));

    // R9
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/uart_bus_bridge.sv
`timescale 1ns/1ps
module uart_bus_bridge
    import ubr_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int BAUD       = 38400,
    parameter int DEPTH      = 256,
    parameter int RTS_MARGIN = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_reg,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       txd,
    input  logic       rxd,
    input  logic       cts_i,
    output logic       rts_o
);
    localparam int DIV = CLK_HZ / (BAUD * 16);
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = AW + 1;
    localparam logic [CW-1:0] FULL_CNT   = CW'(DEPTH);
    localparam logic [CW-1:0] MARGIN_CNT = CW'(RTS_MARGIN);

    logic          tick;
    logic [1:0]    rxd_sync, cts_sync;
    logic          cts_used, cts_block;
    logic          hold_busy;
    logic          push, pop, empty, full;
    logic [7:0]    push_data, head, status;
    logic [CW-1:0] count, free_cnt;

    ubr_tick #(.DIV(DIV)) i_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_sync <= 2'b11;
            cts_sync <= 2'b11;
        end else begin
            rxd_sync <= {rxd_sync[0], rxd};
            cts_sync <= {cts_sync[0], cts_i};
        end
    end

    // CTS presence decided while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) cts_used <= ~cts_i;
    end

    assign cts_block = cts_used & cts_sync[1];

    ubr_tx i_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .wr_en(bus_sel & bus_wr), .wr_hex(bus_reg), .wr_data(bus_wdata),
        .cts_block(cts_block), .hold_busy(hold_busy), .txd(txd)
    );

    ubr_rx i_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_s(rxd_sync[1]),
        .push(push), .push_data(push_data)
    );

    ubr_ring #(.DEPTH(DEPTH)) i_ring (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop(pop), .head(head), .count(count), .empty(empty), .full(full)
    );

    assign status   = {6'b0, ~empty, ~hold_busy & ~cts_block};
    assign pop      = bus_sel & ~bus_wr & ~bus_reg & ~empty;
    assign free_cnt = FULL_CNT - count;

    always_comb begin
        if (bus_sel && !bus_wr)
            bus_rdata = bus_reg ? status : (empty ? 8'h00 : head);
        else
            bus_rdata = 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rts_o <= 1'b1;
        else        rts_o <= (free_cnt > MARGIN_CNT);
    end

    // R10
    rts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt <= MARGIN_CNT) |=> !rts_o);

    // R10
    rts_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt > MARGIN_CNT) |=> rts_o);

    // R9 full flag only with a full count path
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !rts_o || (RTS_MARGIN < 0));
endmodule

// File: tb/test_uart_bus_bridge.sv
`timescale 1ns/1ps
module test_uart_bus_bridge;
    localparam int BAUD   = 38400;
    localparam int CLK_HZ = BAUD * 32;   // two clocks per tick, 32 per bit
    localparam int DEPTH  = 32;
    localparam int MARGIN = 4;
    localparam int BITC   = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_reg = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic txd, rts_o;
    logic rxd = 1'b1;
    logic cts_i = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] cap [128];
    int cap_n = 0;

    always #10 clk = ~clk;

    uart_bus_bridge #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH), .RTS_MARGIN(MARGIN))
    i_uart_bus_bridge (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_reg(bus_reg), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .txd(txd), .rxd(rxd), .cts_i(cts_i), .rts_o(rts_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] digit(input int n);
        return (n < 10) ? 8'(48 + n) : 8'(55 + n);
    endfunction

    task automatic bus_write(input logic r, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_reg = r; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic r, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_reg = r;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic ser_send(input logic [7:0] b, input logic good);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        rxd = good;
        repeat (good ? BITC : 24) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
    endtask

    task automatic wait_caps(input int target);
        int t = 0;
        while (cap_n < target && t < 3000) begin
            @(negedge clk);
            t++;
        end
    endtask

    // serial monitor on txd: mid-bit sampling
    always begin
        logic [7:0] b;
        @(negedge txd);
        if (rst_n) begin
            repeat (16) @(negedge clk);
            checks++;
            if (txd !== 1'b0) begin
                errors++;
                $display("FAIL R2 start bit actual=%b expected=0", txd);
            end
            for (int i = 0; i < 8; i++) begin
                repeat (BITC) @(negedge clk);
                b[i] = txd;
            end
            repeat (BITC) @(negedge clk);
            checks++;
            if (txd !== 1'b1) begin
                errors++;
                $display("FAIL R2 stop bit actual=%b expected=1", txd);
            end
            if (cap_n < 128) cap[cap_n] = b;
            cap_n++;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 txd", {7'b0, txd}, 8'h01);
        check("R1 rts", {7'b0, rts_o}, 8'h01);
        bus_read(1'b1, d); check("R1 status", d, 8'h01);
        bus_read(1'b0, d); check("R1 data empty", d, 8'h00);

        // R2 plain byte sweep
        begin
            logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h01, 8'h80};
            for (int k = 0; k < 6; k++) begin
                base = cap_n;
                bus_write(1'b0, pats[k]);
                wait_caps(base + 1);
                check("R2 byte", cap[base], pats[k]);
            end
        end

        // R3 hex print over every nibble value in both positions
        for (int k = 0; k < 16; k++) begin
            base = cap_n;
            bus_write(1'b1, {4'(k), 4'(15 - k)});
            wait_caps(base + 2);
            check("R3 high digit", cap[base], digit(k));
            check("R3 low digit", cap[base + 1], digit(15 - k));
        end
        repeat (40) @(negedge clk);

        // R5 queueing: A in flight, B held, C ignored
        base = cap_n;
        bus_write(1'b0, 8'hC1);
        bus_write(1'b0, 8'hC2);
        bus_read(1'b1, d); check("R4 R5 status busy", d, 8'h00);
        bus_write(1'b0, 8'hC3);
        wait_caps(base + 2);
        repeat (1000) @(negedge clk);
        check("R5 first", cap[base], 8'hC1);
        check("R5 second", cap[base + 1], 8'hC2);
        check("R5 count", 8'(cap_n - base), 8'd2);

        // R6 CTS honoured (low at reset)
        cts_i = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(1'b1, d); check("R6 status blocked", d, 8'h00);
        base = cap_n;
        bus_write(1'b0, 8'h5A);
        repeat (800) @(negedge clk);
        check("R6 held", 8'(cap_n - base), 8'd0);
        cts_i = 1'b0;
        wait_caps(base + 1);
        check("R6 released", cap[base], 8'h5A);
        repeat (40) @(negedge clk);

        // R7 R8 receive with a bad frame in between
        ser_send(8'hA7, 1'b1);
        ser_send(8'h55, 1'b0);
        ser_send(8'h1E, 1'b1);
        ser_send(8'h80, 1'b1);
        bus_read(1'b1, d); check("R4 R8 status pending", d, 8'h03);
        bus_read(1'b1, d); check("R8 status no pop", d, 8'h03);
        bus_read(1'b0, d); check("R7 R8 first", d, 8'hA7);
        bus_read(1'b0, d); check("R7 second (bad frame dropped)", d, 8'h1E);
        bus_read(1'b0, d); check("R8 third", d, 8'h80);
        bus_read(1'b1, d); check("R8 status cleared", d, 8'h01);
        bus_read(1'b0, d); check("R11 empty data", d, 8'h00);
        bus_read(1'b1, d); check("R11 status unchanged", d, 8'h01);

        // R9 R10 fill past capacity
        for (int i = 0; i < DEPTH + 1; i++) begin
            ser_send(8'(8'h40 + i), 1'b1);
            if (i == DEPTH - MARGIN - 2) check("R10 rts above margin", {7'b0, rts_o}, 8'h01);
            if (i == DEPTH - MARGIN - 1) check("R10 rts at margin", {7'b0, rts_o}, 8'h00);
        end
        for (int i = 0; i < DEPTH; i++) begin
            bus_read(1'b0, d);
            check("R9 drain order", d, 8'(8'h40 + i));
            if (i == 3) begin
                repeat (2) @(negedge clk);
                check("R10 rts still low", {7'b0, rts_o}, 8'h00);
            end
            if (i == 4) begin
                repeat (2) @(negedge clk);
                check("R10 rts back high", {7'b0, rts_o}, 8'h01);
            end
        end
        bus_read(1'b1, d); check("R9 overflow byte dropped", d, 8'h01);

        // R6 CTS ignored when high during reset
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        cts_i = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        bus_read(1'b1, d); check("R6 ignored status", d, 8'h01);
        base = cap_n;
        bus_write(1'b0, 8'h3E);
        wait_caps(base + 1);
        check("R6 ignored send", cap[base], 8'h3E);

        repeat (50) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule